// File: doc/BRIEF.md
# Paged Memory Mapper Register Unit

This block sits between an 8-bit CPU bus with a 64 KB address space and a 512 KB RAM. It splits the CPU space into four 16 KB quarters. Each quarter has a page register that names the 32-entry RAM block seen through it. Software loads the page registers with I/O writes to ports 0xFC through 0xFF. It may also read them back through the same ports, if the build parameter for read-back is set.

One index path serves both kinds of cycle. During an I/O cycle the index is address bits A1:A0. During a memory cycle it is A15:A14. The chosen register then replaces the CPU's top two address bits. The RAM chip enable, output enable and write enable come straight from the mapper slot select and the CPU read and write strobes.

Top module: `page_mapper`

## Requirements
- R1: After reset, page registers 0, 1, 2 and 3 hold 3, 2, 1 and 0. A memory access to quarter q therefore gives ram_addr_o[18:14] = 3 - q.
- R2: An I/O write to port 0xFC + k (k = 0..3) stores data_i[4:0] in register k at the clock edge that samples it. A memory access in the next cycle already uses the new value.
- R3: The I/O decode compares only addr_i[7:0] against 0xFC..0xFF and ignores addr_i[15:8]. An I/O write whose low byte is outside that range changes no register.
- R4: ram_addr_o[13:0] always equals addr_i[13:0].
- R5: During a memory access, addr_i[15:14] selects the register that drives ram_addr_o[18:14].
- R6: With read-back enabled, an I/O read of port 0xFC + k raises data_oe_o. It drives data_o = {3'b111, register k}, so bits above the 5-bit register read as 1.
- R7: data_oe_o is low, and data_o is 0, unless an I/O read to one of the four ports is active.
- R8: ram_ce_o = mem_req_i & slot_sel_i. ram_oe_o = ram_ce_o & rd_i. ram_we_o = ram_ce_o & wr_i.
- R9: A memory write never changes a register. Data bits D7:D5 of an I/O write are not stored.
- R10: With read-back disabled (READBACK_EN = 0), data_oe_o stays low even during I/O reads of the mapper ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address bus |
| data_i | input | 8 | CPU write data |
| io_req_i | input | 1 | An I/O cycle is active |
| mem_req_i | input | 1 | A memory cycle is active |
| rd_i | input | 1 | Read strobe, active high |
| wr_i | input | 1 | Write strobe, active high |
| slot_sel_i | input | 1 | The mapper slot is selected |
| data_o | output | 8 | Read-back data |
| data_oe_o | output | 1 | Drive enable for read-back data |
| ram_addr_o | output | 19 | RAM address: page in bits 18:14, offset in bits 13:0 |
| ram_ce_o | output | 1 | RAM chip enable, active high |
| ram_oe_o | output | 1 | RAM output enable, active high |
| ram_we_o | output | 1 | RAM write enable, active high |

## Verification
The assertions check on every cycle that a decoded write lands in the addressed register in the next cycle. They also check that at most one register is write-enabled, that registers hold without a write, and that the data drive and RAM strobes appear only under their qualifying bus cycles. Only the bench scenarios can show the actual mapping. This covers the reset page assignment, the swap from A1:A0 to A15:A14 indexing, the decode that ignores A15:A8 and rejects 0xFB, the all-ones fill above the register on read-back, and the silent port of a build with read-back disabled.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int unsigned CPU_ADDR_W = 16;
  localparam int unsigned CPU_DATA_W = 8;
  localparam int unsigned OFFSET_W   = 14;
  localparam int unsigned NUM_PAGES  = 4;
  localparam int unsigned IDX_W      = $clog2(NUM_PAGES);
  typedef logic [IDX_W-1:0] page_idx_t;
endpackage

// File: rtl/mapper_port_decode.sv
module mapper_port_decode
  import mapper_pkg::*;
#(
  parameter logic [7:0] PORT_BASE = 8'hFC
) (
  input  logic [CPU_ADDR_W-1:0] addr_i,
  input  logic                  io_req_i,
  input  logic                  rd_i,
  input  logic                  wr_i,
  output page_idx_t             idx_o,
  output logic                  wr_en_o,
  output logic                  rd_en_o
);
  logic port_hit;

  // only the low byte takes part in port decode
  assign port_hit = (addr_i[7:IDX_W] == PORT_BASE[7:IDX_W]);
  assign wr_en_o  = io_req_i & wr_i & port_hit;
  assign rd_en_o  = io_req_i & rd_i & port_hit;
  assign idx_o    = io_req_i ? addr_i[IDX_W-1:0]
                             : addr_i[CPU_ADDR_W-1 -: IDX_W];
endmodule

// File: rtl/mapper_page_regs.sv
module mapper_page_regs
  import mapper_pkg::*;
#(
  parameter int unsigned PAGE_BITS = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  page_idx_t            idx_i,
  input  logic [PAGE_BITS-1:0] wdata_i,
  output logic [PAGE_BITS-1:0] page_o
);
  logic [NUM_PAGES-1:0][PAGE_BITS-1:0] page_q;
  logic [NUM_PAGES-1:0]                we;

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_we
    assign we[g] = wr_en_i && (idx_i == page_idx_t'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PAGES; i++)
        page_q[i] <= PAGE_BITS'(NUM_PAGES - 1 - i);
    end else begin
      for (int i = 0; i < NUM_PAGES; i++)
        if (we[i]) page_q[i] <= wdata_i;
    end
  end

  assign page_o = page_q[idx_i];

  assert_one_we_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we));
  assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> page_q[$past(idx_i)] == $past(wdata_i));
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(page_q));
endmodule

// File: rtl/mapper_addr_compose.sv
module mapper_addr_compose
  import mapper_pkg::*;
#(
  parameter int unsigned PAGE_BITS   = 5,
  parameter bit          READBACK_EN = 1'b1
) (
  input  logic [PAGE_BITS-1:0]          page_i,
  input  logic [OFFSET_W-1:0]           offset_i,
  input  logic                          rd_en_i,
  output logic [PAGE_BITS+OFFSET_W-1:0] ram_addr_o,
  output logic [CPU_DATA_W-1:0]         data_o,
  output logic                          data_oe_o
);
  localparam int unsigned FILL_W = CPU_DATA_W - PAGE_BITS;

  assign ram_addr_o = {page_i, offset_i};

  if (READBACK_EN) begin : g_rb
    assign data_oe_o = rd_en_i;
    assign data_o    = rd_en_i ? {{FILL_W{1'b1}}, page_i} : '0;
  end else begin : g_no_rb
    assign data_oe_o = 1'b0;
    assign data_o    = '0;
  end
endmodule

// File: rtl/page_mapper.sv
module page_mapper
  import mapper_pkg::*;
#(
  parameter int unsigned PAGE_BITS   = 5,
  parameter bit          READBACK_EN = 1'b1,
  parameter logic [7:0]  PORT_BASE   = 8'hFC,
  localparam int unsigned RAM_ADDR_W = PAGE_BITS + OFFSET_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [CPU_ADDR_W-1:0] addr_i,
  input  logic [CPU_DATA_W-1:0] data_i,
  input  logic                  io_req_i,
  input  logic                  mem_req_i,
  input  logic                  rd_i,
  input  logic                  wr_i,
  input  logic                  slot_sel_i,
  output logic [CPU_DATA_W-1:0] data_o,
  output logic                  data_oe_o,
  output logic [RAM_ADDR_W-1:0] ram_addr_o,
  output logic                  ram_ce_o,
  output logic                  ram_oe_o,
  output logic                  ram_we_o
);
  page_idx_t            idx;
  logic                 wr_en, rd_en;
  logic [PAGE_BITS-1:0] page;

  mapper_port_decode #(.PORT_BASE(PORT_BASE)) u_decode (
    .addr_i(addr_i), .io_req_i(io_req_i), .rd_i(rd_i), .wr_i(wr_i),
    .idx_o(idx), .wr_en_o(wr_en), .rd_en_o(rd_en)
  );

  mapper_page_regs #(.PAGE_BITS(PAGE_BITS)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .idx_i(idx),
    .wdata_i(data_i[PAGE_BITS-1:0]), .page_o(page)
  );

  mapper_addr_compose #(.PAGE_BITS(PAGE_BITS), .READBACK_EN(READBACK_EN)) u_compose (
    .page_i(page), .offset_i(addr_i[OFFSET_W-1:0]), .rd_en_i(rd_en),
    .ram_addr_o(ram_addr_o), .data_o(data_o), .data_oe_o(data_oe_o)
  );

  assign ram_ce_o = mem_req_i & slot_sel_i;
  assign ram_oe_o = ram_ce_o & rd_i;
  assign ram_we_o = ram_ce_o & wr_i;

  assert_oe_qual_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (io_req_i && rd_i));
  assert_strobe_qual_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o || ram_oe_o) |-> (mem_req_i && slot_sel_i));
  assert_no_drive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !READBACK_EN |-> !data_oe_o);
endmodule

// File: tb/page_mapper_bench.sv
module page_mapper_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        io_req = 1'b0, mem_req = 1'b0, rd = 1'b0, wr = 1'b0, slot = 1'b0;
  logic [7:0]  dout, dout_n;
  logic        doe, doe_n, ce, oe, we, ce_n, oe_n, we_n;
  logic [18:0] ram_addr, ram_addr_n;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  page_mapper u_page_mapper (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(wdata),
    .io_req_i(io_req), .mem_req_i(mem_req), .rd_i(rd), .wr_i(wr),
    .slot_sel_i(slot), .data_o(dout), .data_oe_o(doe),
    .ram_addr_o(ram_addr), .ram_ce_o(ce), .ram_oe_o(oe), .ram_we_o(we)
  );

  page_mapper #(.READBACK_EN(1'b0)) u_page_mapper_norb (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(wdata),
    .io_req_i(io_req), .mem_req_i(mem_req), .rd_i(rd), .wr_i(wr),
    .slot_sel_i(slot), .data_o(dout_n), .data_oe_o(doe_n),
    .ram_addr_o(ram_addr_n), .ram_ce_o(ce_n), .ram_oe_o(oe_n), .ram_we_o(we_n)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    io_req = 0; mem_req = 0; rd = 0; wr = 0; slot = 0;
  endtask

  task automatic io_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; io_req = 1; wr = 1; rd = 0; mem_req = 0;
    idle();
  endtask

  // memory read at address a; sampled mid-cycle
  task automatic mem_page(logic [15:0] a, output logic [4:0] pg);
    @(negedge clk);
    addr = a; io_req = 0; mem_req = 1; slot = 1; rd = 1; wr = 0;
    #2 pg = ram_addr[18:14];
    idle();
  endtask

  task automatic t_reset();
    logic [4:0] pg;
    check("R7 reset oe", {31'd0, doe}, 32'd0);
    for (int q = 0; q < 4; q++) begin
      mem_page({q[1:0], 14'h0}, pg);
      check("R1 reset page", {27'd0, pg}, 32'(3 - q));
    end
  endtask

  task automatic t_write_map();
    logic [4:0] pg;
    io_write(16'h00FC, 8'h11);
    io_write(16'h00FD, 8'h07);
    io_write(16'h00FE, 8'h1F);
    io_write(16'h00FF, 8'h0A);
    // write then memory access in the very next cycle (R2)
    @(negedge clk);
    addr = 16'h00FE; wdata = 8'h05; io_req = 1; wr = 1;
    @(negedge clk);
    io_req = 0; wr = 0; addr = 16'h8000; mem_req = 1; slot = 1; rd = 1;
    #2 check("R2 next-cycle use", {27'd0, ram_addr[18:14]}, 32'h05);
    idle();
    mem_page(16'h0000, pg); check("R2/R5 q0", {27'd0, pg}, 32'h11);
    mem_page(16'h4000, pg); check("R2/R5 q1", {27'd0, pg}, 32'h07);
    mem_page(16'hC000, pg); check("R2/R5 q3", {27'd0, pg}, 32'h0A);
  endtask

  task automatic t_decode();
    logic [4:0] pg;
    io_write(16'h12FD, 8'h19);
    mem_page(16'h4000, pg); check("R3 high byte ignored", {27'd0, pg}, 32'h19);
    io_write(16'h00FB, 8'h02);
    io_write(16'hFF7C, 8'h02);
    mem_page(16'hC000, pg); check("R3 FB/7C no write q3", {27'd0, pg}, 32'h0A);
    mem_page(16'h4000, pg); check("R3 FB/7C no write q1", {27'd0, pg}, 32'h19);
  endtask

  task automatic t_offset();
    @(negedge clk);
    addr = 16'h6ABC; mem_req = 1; slot = 1; rd = 1;
    #2 check("R4 offset", {18'd0, ram_addr[13:0]}, 32'h2ABC);
    check("R5 quarter 1 page", {27'd0, ram_addr[18:14]}, 32'h19);
    idle();
  endtask

  task automatic t_readback();
    @(negedge clk);
    addr = 16'h34FF; io_req = 1; rd = 1;
    #2 check("R6 oe", {31'd0, doe}, 32'd1);
    check("R6 data FF", {24'd0, dout}, 32'hEA);
    idle();
    @(negedge clk);
    addr = 16'h00FD; io_req = 1; rd = 1;
    #2 check("R6 data FD", {24'd0, dout}, 32'hF9);
    check("R10 no-readback build oe", {31'd0, doe_n}, 32'd0);
    idle();
  endtask

  task automatic t_no_drive();
    @(negedge clk);
    addr = 16'h00FC; mem_req = 1; slot = 1; rd = 1;
    #2 check("R7 mem read no drive", {23'd0, doe, dout}, 32'd0);
    idle();
    @(negedge clk);
    addr = 16'h00FA; io_req = 1; rd = 1;
    #2 check("R7 other port no drive", {23'd0, doe, dout}, 32'd0);
    idle();
  endtask

  task automatic t_strobes();
    @(negedge clk);
    addr = 16'h1234; mem_req = 1; slot = 0; rd = 1;
    #2 check("R8 no slot", {29'd0, ce, oe, we}, 32'b000);
    slot = 1;
    #2 check("R8 read", {29'd0, ce, oe, we}, 32'b110);
    rd = 0; mem_req = 0;
    idle();
    @(negedge clk);
    io_req = 1; wr = 1; slot = 1; addr = 16'h00F0;
    #2 check("R8 io cycle", {29'd0, ce, oe, we}, 32'b000);
    idle();
  endtask

  task automatic t_mem_write();
    logic [4:0] pg;
    @(negedge clk);
    addr = 16'h00FC; wdata = 8'h03; mem_req = 1; slot = 1; wr = 1;
    #2 check("R8 write", {29'd0, ce, oe, we}, 32'b101);
    idle();
    mem_page(16'h0000, pg); check("R9 mem write ignored", {27'd0, pg}, 32'h11);
    io_write(16'h00FC, 8'hE6);
    @(negedge clk);
    addr = 16'h00FC; io_req = 1; rd = 1;
    #2 check("R9 upper bits dropped", {24'd0, dout}, 32'hE6);
    idle();
    mem_page(16'h0000, pg); check("R9 page after E6", {27'd0, pg}, 32'h06);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_map();
    t_decode();
    t_offset();
    t_readback();
    t_no_drive();
    t_strobes();
    t_mem_write();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule